// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

A countdown watchdog held in one 16-bit control word. Software writes the word to load a count and to start or stop the countdown. While the stored word has its enable bit set, a write is taken only when its key field is the bitwise complement of the key already stored. Any other write is dropped without effect, so a runaway program that keeps writing the same value cannot keep the watchdog alive.

The count falls by one on each cycle in which the slow tick input is high. The tick is generated elsewhere, at about 760 pulses per second. When a running count reaches zero the block raises a one-cycle system reset request and stops. The remaining count is always visible on a status output. Sequencing the chip reset from the request is handled outside this block.

Top module: `wdog_guard`

## Requirements
- R1: After reset the stored word is zero, the watchdog is stopped, `remain` is 0 and `rst_req` is 0.
- R2: When the stored enable bit (bit 8) is 0, a write is accepted whatever its key. This includes the first write after reset.
- R3: An accepted write loads `remain` from bits [8:0] of the written word and stores bits [15:0] as the new control word. The enable bit is part of this 9-bit field, so a write that starts the watchdog loads a value from 256 to 511.
- R4: An accepted write whose bits [8:0] are all zero loads 256.
- R5: While the watchdog is running, each cycle with `tick` high lowers `remain` by one. A cycle with `tick` low leaves it unchanged.
- R6: An accepted write with bit 8 at 0 stops the countdown. Ticks then leave `remain` unchanged.
- R7: When the stored enable bit is 1, a write whose key (bits [15:9]) is not the 7-bit complement of the stored key is ignored. `remain`, the running state and the stored key all stay as they were.
- R8: When the stored enable bit is 1, a write whose key equals the complement of the stored key is accepted.
- R9: When a tick brings a running count from 1 to 0, `rst_req` is high for exactly the next cycle. The watchdog then stops with `remain` held at 0.
- R10: An accepted write in the same cycle as a tick takes priority, and `remain` takes the loaded value without a decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow countdown enable, one cycle per count step |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word: key [15:9], enable [8], count [8:0] |
| rst_req | output | 1 | One-cycle system reset request on expiry |
| remain | output | 9 | Remaining count |

## Verification
The hardest state to reach is expiry while the stored word still demands a complemented key. Only an enabling write can reach it, and that write loads at least 256, so the stimulus ticks on every cycle for several hundred cycles. It then checks that the pulse is a single cycle and that the count stays at zero afterwards. Because the key check survives expiry, the bench next proves that only the complemented key revives the block. A write that arrives together with a tick is driven on purpose to show the load wins.

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int KEY_W = 7,
  parameter int CNT_W = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   wr_en,
  input  logic [KEY_W+CNT_W-1:0] wr_data,
  output logic                   rst_req,
  output logic [CNT_W-1:0]       remain
);
  localparam int CTL_W  = KEY_W + CNT_W;
  localparam int EN_POS = CNT_W - 1;
  localparam logic [CNT_W-1:0] ZERO_LOAD = CNT_W'(1) << EN_POS;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CTL_W-1:0] ctl;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic             req;

  wire [KEY_W-1:0] key_new = wr_data[CTL_W-1:CNT_W];
  wire [KEY_W-1:0] key_old = ctl[CTL_W-1:CNT_W];
  wire             armed   = ctl[EN_POS];
  wire             accept  = wr_en && (!armed || key_new == ~key_old);
  wire [CNT_W-1:0] field   = wr_data[CNT_W-1:0];
  wire [CNT_W-1:0] load    = (field == '0) ? ZERO_LOAD : field;
  wire             step    = run && tick && !accept;
  wire             expire  = step && cnt == ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
      cnt <= '0;
      run <= 1'b0;
      req <= 1'b0;
    end else begin
      req <= expire;
      if (accept) begin
        ctl <= wr_data;
        cnt <= load;
        run <= wr_data[EN_POS];
      end else if (step) begin
        cnt <= cnt - ONE;
        if (expire) run <= 1'b0;
      end
    end
  end

  assign rst_req = req;
  assign remain  = cnt;
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic             run,
  input logic             rst_req,
  input logic [CNT_W-1:0] remain
);
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_pulse_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (remain == '0 && !run));

  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && tick && run) |=> remain == $past(remain) - CNT_W'(1));

  assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !tick) |=> $stable(remain));

  assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !run) |=> $stable(remain));

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && remain == '0) |=> remain == '0);
endmodule

bind wdog_guard wdog_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
  .run(run), .rst_req(rst_req), .remain(remain)
);

// File: tb/wdog_guard_bench.sv
module wdog_guard_bench;
  logic        clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [15:0] wr_data = '0;
  logic        rst_req;
  logic [8:0]  remain;
  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdog_guard u_wdog_guard (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_data(wr_data), .rst_req(rst_req), .remain(remain));

  // behavioural reference
  int m_cnt = 0, m_key = 0, m_req = 0;
  bit m_en = 0, m_run = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_key = 0; m_en = 0; m_run = 0; m_req = 0;
    end else begin
      bit acc;
      acc = wr_en && (!m_en || int'(wr_data[15:9]) == (~m_key & 127));
      m_req = 0;
      if (acc) begin
        m_key = wr_data[15:9];
        m_en  = wr_data[8];
        m_run = wr_data[8];
        m_cnt = (wr_data[8:0] == 0) ? 256 : int'(wr_data[8:0]);
      end else if (m_run && tick) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin m_run = 0; m_req = 1; end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R5 model remain", remain, m_cnt);
    chk("R9 model rst_req", rst_req, m_req);
    if (rst_req) pulses++;
  end

  task automatic wr(int key, bit en, int low, bit tk = 0);
    @(negedge clk);
    wr_en = 1; tick = tk; wr_data = {key[6:0], en, low[7:0]};
    @(negedge clk);
    wr_en = 0; tick = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
    end
    @(negedge clk); tick = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog timeout actual 1 expected 0");
    finish_run();
  end

  initial begin
    idle(2);
    chk("R1 reset remain", remain, 0);
    chk("R1 reset rst_req", rst_req, 0);
    rst_n = 1;
    idle(2);
    chk("R1 after release remain", remain, 0);

    wr(7'h15, 1, 8'h05);
    chk("R2 R3 first write load", remain, 261);
    ticks(4);
    chk("R5 four ticks", remain, 257);
    idle(3);
    chk("R5 no tick hold", remain, 257);

    wr(7'h15, 1, 8'h10);
    chk("R7 wrong key ignored", remain, 257);
    ticks(1);
    chk("R7 still running", remain, 256);

    wr(7'h6A, 0, 8'h00);
    chk("R4 R8 zero field loads 256", remain, 256);
    ticks(3);
    chk("R6 stopped hold", remain, 256);

    wr(7'h33, 1, 8'h02);
    chk("R2 any key when stored enable clear", remain, 258);

    wr(7'h4C, 1, 8'h07, 1);
    chk("R10 write beats tick", remain, 263);

    pulses = 0;
    ticks(262);
    chk("R9 one above expiry", remain, 1);
    chk("R9 no early pulse", pulses, 0);
    ticks(1);
    chk("R9 expired remain", remain, 0);
    ticks(5);
    chk("R9 single pulse", pulses, 1);
    chk("R9 held at zero", remain, 0);

    wr(7'h4C, 0, 8'h03);
    chk("R7 stale key after expiry ignored", remain, 0);
    wr(7'h33, 0, 8'h03);
    chk("R8 complement key after expiry", remain, 3);
    ticks(2);
    chk("R6 stopped after revive", remain, 3);

    idle(2);
    finish_run();
  end
endmodule